// File: doc/BRIEF.md
# Four-Source Maskable Interrupt Controller

This block merges four interrupt causes from a data-acquisition front end into one host interrupt line. The causes are a sample FIFO holding at least one result, a DMA terminal count, the end of an acquisition run, and a rising edge on an external counter output. Each cause has a sticky status bit that the host reads to find out which cause raised the interrupt. An acquisition run that ends by error is marked by two further sticky bits, overflow and overrun.

The enable bits and the clear strobes come from a register file outside this block, which also owns the bus decode. Each cause has its own enable, and one global enable masks the line. The terminal-count cause needs the DMA enable as well. Each cause is cleared by its own set of strobes. The general converter clear resets the conversion, terminal-count and acquisition-done causes and both error bits at once. Status bits latch even when their cause is disabled; the enables mask only the output.

Top module: `daq_irq_ctrl`

## Requirements
- R1: `irq_o` is high in a cycle only if `glb_en_i` was high in the cycle before. The output is registered, so it follows its inputs by one clock.
- R2: `irq_o` equals the registered OR of every latched cause ANDed with its enable. Bit positions in `stat_o` and `en_i` are: 0 conversion, 1 terminal count, 2 acquisition done, 3 external edge. The terminal-count term also needs `dma_en_i`.
- R3: `stat_o[0]` sets at the clock edge where `fifo_nempty_i` is high. It clears on `fifo_rd_i` or `clr_adc_i` when `fifo_nempty_i` is low.
- R4: `stat_o[1]` sets on a `tc_evt_i` pulse. It clears on `clr_tc_i` or `clr_adc_i`.
- R5: `stat_o[2]` sets on a `done_evt_i` pulse. It clears only on `clr_adc_i`. `clr_tc_i`, `clr_ext_i` and `fifo_rd_i` leave it unchanged.
- R6: `err_ovf_o` and `err_ovr_o` latch on `ovf_evt_i` and `ovr_evt_i`, and only `clr_adc_i` clears them. `done_err_o` is high when the acquisition-done status is set and either error bit is set. When the run completes normally, done is set with `done_err_o` low.
- R7: `stat_o[3]` sets on a rising edge of `ext_out_i` after a two-flop synchronizer. It shows three clocks after the input rises. A level held high does not set it again once it has been cleared.
- R8: `stat_o[3]` clears only on `clr_ext_i`. `clr_adc_i` leaves it unchanged.
- R9: When a cause's set event and one of its clear strobes occur in the same cycle, the status ends up set.
- R10: Status bits and error bits latch while their enables, `dma_en_i` or `glb_en_i` are low.
- R11: After reset, all status bits, error bits and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_nempty_i | input | 1 | Sample FIFO holds data (level) |
| fifo_rd_i | input | 1 | Host read of the sample FIFO (strobe) |
| tc_evt_i | input | 1 | DMA terminal count (pulse) |
| done_evt_i | input | 1 | Acquisition run finished (pulse) |
| ovf_evt_i | input | 1 | FIFO overflow detected (pulse) |
| ovr_evt_i | input | 1 | Conversion overrun detected (pulse) |
| ext_out_i | input | 1 | External counter output, asynchronous |
| clr_adc_i | input | 1 | General converter clear strobe |
| clr_tc_i | input | 1 | Terminal-count clear strobe |
| clr_ext_i | input | 1 | External-edge clear strobe |
| glb_en_i | input | 1 | Global interrupt enable |
| dma_en_i | input | 1 | DMA enable |
| en_i | input | 4 | Per-cause enables (bit map as in R2) |
| stat_o | output | 4 | Per-cause status (bit map as in R2) |
| err_ovf_o | output | 1 | Sticky overflow error |
| err_ovr_o | output | 1 | Sticky overrun error |
| done_err_o | output | 1 | Acquisition ended by error |
| irq_o | output | 1 | Host interrupt line |

## Verification
The assertions assume that every input except `ext_out_i` is synchronous to `clk` and that the event inputs are single-cycle pulses. They also assume that the FIFO flag only drops after the FIFO is read. The bench drives all inputs at the falling edge and keeps event and clear strobes one cycle wide. It changes `ext_out_i` only on whole cycles, so the synchronizer sees clean levels. The register-to-output delay of each path is counted before sampling: one clock for a status bit, two for the interrupt line, and three for the external-edge status.

// File: rtl/daq_irq_pkg.sv
package daq_irq_pkg;
    localparam int NUM_CAUSE = 4;
    localparam int NUM_ERR   = 2;
    localparam int NUM_LATCH = NUM_CAUSE + NUM_ERR;

    typedef enum logic [2:0] {
        SRC_CONV = 3'd0,
        SRC_TC   = 3'd1,
        SRC_DONE = 3'd2,
        SRC_EXT  = 3'd3,
        SRC_OVF  = 3'd4,
        SRC_OVR  = 3'd5
    } src_e;

    typedef logic [NUM_CAUSE-1:0] cause_vec_t;
    typedef logic [NUM_LATCH-1:0] latch_vec_t;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sync = {state_q.sync[SYNC_STAGES-2:0], async_i};
        state_d.prev = state_q.sync[MSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rise_o = state_q.sync[MSB] & ~state_q.prev;

    // R7: one rising edge gives a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/irq_cause_latch.sv
module irq_cause_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic stat_o
);
    typedef struct packed {
        logic stat;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_i) begin
            state_d.stat = 1'b1;
        end else if (clr_i) begin
            state_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_o = state_q.stat;

    // R9: set beats clear in the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> stat_o);
    // R10: a latched bit holds without a clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !clr_i) |=> stat_o);
    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !stat_o);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] en_i,
    input  logic         glb_en_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } state_t;

    state_t       state_d, state_q;
    logic [N-1:0] masked;

    always_comb begin
        masked      = stat_i & en_i;
        state_d     = state_q;
        state_d.irq = glb_en_i & (|masked);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.irq;

    // R1: no interrupt unless the global enable was set
    a_r1_glb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> !irq_o);
    // R2: no enabled latched cause -> line low next cycle
    a_r2_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & en_i) == '0) |=> !irq_o);
    a_r2_cause_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_i && ((stat_i & en_i) != '0)) |=> irq_o);
endmodule

// File: rtl/daq_irq_ctrl.sv
module daq_irq_ctrl
    import daq_irq_pkg::*;
#(
    parameter int EXT_SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_nempty_i,
    input  logic                 fifo_rd_i,
    input  logic                 tc_evt_i,
    input  logic                 done_evt_i,
    input  logic                 ovf_evt_i,
    input  logic                 ovr_evt_i,
    input  logic                 ext_out_i,
    input  logic                 clr_adc_i,
    input  logic                 clr_tc_i,
    input  logic                 clr_ext_i,
    input  logic                 glb_en_i,
    input  logic                 dma_en_i,
    input  logic [NUM_CAUSE-1:0] en_i,
    output logic [NUM_CAUSE-1:0] stat_o,
    output logic                 err_ovf_o,
    output logic                 err_ovr_o,
    output logic                 done_err_o,
    output logic                 irq_o
);
    logic       ext_rise;
    latch_vec_t set_vec, clr_vec, lat_q;
    cause_vec_t en_eff;

    irq_sync_edge #(.SYNC_STAGES(EXT_SYNC_STAGES)) ext_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_out_i),
        .rise_o  (ext_rise)
    );

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        set_vec[SRC_CONV] = fifo_nempty_i;
        clr_vec[SRC_CONV] = fifo_rd_i | clr_adc_i;
        set_vec[SRC_TC]   = tc_evt_i;
        clr_vec[SRC_TC]   = clr_tc_i | clr_adc_i;
        set_vec[SRC_DONE] = done_evt_i;
        clr_vec[SRC_DONE] = clr_adc_i;
        set_vec[SRC_EXT]  = ext_rise;
        clr_vec[SRC_EXT]  = clr_ext_i;
        set_vec[SRC_OVF]  = ovf_evt_i;
        clr_vec[SRC_OVF]  = clr_adc_i;
        set_vec[SRC_OVR]  = ovr_evt_i;
        clr_vec[SRC_OVR]  = clr_adc_i;

        en_eff         = en_i;
        en_eff[SRC_TC] = en_i[SRC_TC] & dma_en_i;
    end

    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
        irq_cause_latch latch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .stat_o (lat_q[g])
        );
    end

    irq_combine #(.N(NUM_CAUSE)) comb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_i   (lat_q[NUM_CAUSE-1:0]),
        .en_i     (en_eff),
        .glb_en_i (glb_en_i),
        .irq_o    (irq_o)
    );

    assign stat_o     = lat_q[NUM_CAUSE-1:0];
    assign err_ovf_o  = lat_q[SRC_OVF];
    assign err_ovr_o  = lat_q[SRC_OVR];
    assign done_err_o = lat_q[SRC_DONE] & (lat_q[SRC_OVF] | lat_q[SRC_OVR]);

    // R5: done survives every strobe except the converter clear
    a_r5_done_clear_only_adc: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[SRC_DONE] && !clr_adc_i) |=> stat_o[SRC_DONE]);
    // R8: external cause ignores the converter clear
    a_r8_ext_ignores_adc: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[SRC_EXT] && !clr_ext_i) |=> stat_o[SRC_EXT]);
    // R6: converter clear wipes error bits when no new error arrives
    a_r6_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_adc_i && !ovf_evt_i && !ovr_evt_i) |=> (!err_ovf_o && !err_ovr_o));
    // R2: terminal count alone cannot interrupt without the DMA enable
    a_r2_tc_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en_i && ((stat_o & en_i & 4'b1101) == '0)) |=> !irq_o);
endmodule

// File: tb/daq_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module daq_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_nempty, fifo_rd, tc_evt, done_evt, ovf_evt, ovr_evt, ext_out;
    logic       clr_adc, clr_tc, clr_ext, glb_en, dma_en;
    logic [3:0] en;
    logic [3:0] stat;
    logic       err_ovf, err_ovr, done_err, irq;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    daq_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .fifo_nempty_i(fifo_nempty), .fifo_rd_i(fifo_rd),
        .tc_evt_i(tc_evt), .done_evt_i(done_evt),
        .ovf_evt_i(ovf_evt), .ovr_evt_i(ovr_evt), .ext_out_i(ext_out),
        .clr_adc_i(clr_adc), .clr_tc_i(clr_tc), .clr_ext_i(clr_ext),
        .glb_en_i(glb_en), .dma_en_i(dma_en), .en_i(en),
        .stat_o(stat), .err_ovf_o(err_ovf), .err_ovr_o(err_ovr),
        .done_err_o(done_err), .irq_o(irq)
    );

    // {glb_en, dma_en, en[3:0], expected irq}; all four causes latched
    localparam logic [6:0] VEC [10] = '{
        7'b0_1_1111_0,
        7'b1_1_0000_0,
        7'b1_0_0010_0,
        7'b1_1_0010_1,
        7'b1_0_0001_1,
        7'b1_0_0100_1,
        7'b1_0_1000_1,
        7'b0_0_1111_0,
        7'b1_0_1110_1,
        7'b1_1_1111_1
    };

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        step();
        sig = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {fifo_nempty, fifo_rd, tc_evt, done_evt, ovf_evt, ovr_evt, ext_out} = '0;
        {clr_adc, clr_tc, clr_ext, glb_en, dma_en} = '0;
        en = '0;
        step(3);
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 stat", stat, 4'h0);
        chk("R11 err", {err_ovf, err_ovr, done_err}, 3'b000);
        chk("R11 irq", irq, 1'b0);

        // R10: latch every cause with everything disabled
        fifo_nempty = 1'b1; step(); fifo_nempty = 1'b0;
        pulse(tc_evt);
        pulse(done_evt);
        ext_out = 1'b1;
        step(3);
        chk("R10 latched while disabled", stat, 4'hF);
        chk("R10 irq masked", irq, 1'b0);

        // R2 / R1: enable mask table
        foreach (VEC[k]) begin
            {glb_en, dma_en, en} = VEC[k][6:1];
            step();
            chk(VEC[k][6] ? "R2 mask vector" : "R1 global gate", irq, VEC[k][0]);
        end
        glb_en = 1'b1; dma_en = 1'b1; en = 4'hF;

        // R8: converter clear leaves the external cause; R3 R4 R5 cleared
        pulse(clr_adc);
        chk("R8 ext kept on adc clear", stat, 4'b1000);
        pulse(clr_ext);
        chk("R8 ext cleared", stat, 4'h0);
        step();
        chk("R2 no cause no irq", irq, 1'b0);

        // R7: held high level does not set again
        step(5);
        chk("R7 level no retrigger", stat[3], 1'b0);
        ext_out = 1'b0; step(3);
        ext_out = 1'b1; step(2);
        chk("R7 not before 3 clocks", stat[3], 1'b0);
        step();
        chk("R7 rising edge", stat[3], 1'b1);
        step();
        chk("R7 irq follows", irq, 1'b1);
        ext_out = 1'b0;
        pulse(clr_ext);

        // R3: conversion cause
        fifo_nempty = 1'b1; step();
        chk("R3 set on nonempty", stat[0], 1'b1);
        fifo_rd = 1'b1; step(); fifo_rd = 1'b0;
        chk("R9 set wins over read", stat[0], 1'b1);
        fifo_nempty = 1'b0;
        pulse(fifo_rd);
        chk("R3 read clears", stat[0], 1'b0);
        fifo_nempty = 1'b1; step(); fifo_nempty = 1'b0;
        pulse(clr_adc);
        chk("R3 adc clear", stat[0], 1'b0);

        // R4: terminal count
        pulse(tc_evt);
        chk("R4 set", stat[1], 1'b1);
        pulse(clr_tc);
        chk("R4 own clear", stat[1], 1'b0);
        pulse(tc_evt);
        pulse(clr_adc);
        chk("R4 adc clear", stat[1], 1'b0);
        tc_evt = 1'b1; clr_tc = 1'b1; step(); tc_evt = 1'b0; clr_tc = 1'b0;
        chk("R9 tc set wins", stat[1], 1'b1);
        pulse(clr_tc);

        // R5: done cleared only by converter clear
        pulse(done_evt);
        pulse(clr_tc);
        pulse(clr_ext);
        pulse(fifo_rd);
        chk("R5 done kept", stat[2], 1'b1);
        chk("R6 normal completion", done_err, 1'b0);
        done_evt = 1'b1; clr_adc = 1'b1; step(); done_evt = 1'b0; clr_adc = 1'b0;
        chk("R9 done set wins", stat[2], 1'b1);
        pulse(clr_adc);
        chk("R5 adc clears done", stat[2], 1'b0);

        // R6: error qualifiers
        pulse(ovf_evt);
        pulse(done_evt);
        chk("R6 overflow error", {err_ovf, err_ovr, done_err}, 3'b101);
        pulse(clr_tc);
        chk("R6 err kept", err_ovf, 1'b1);
        pulse(clr_adc);
        chk("R6 cleared", {err_ovf, err_ovr, done_err, stat[2]}, 4'b0000);
        pulse(ovr_evt);
        pulse(done_evt);
        chk("R6 overrun error", {err_ovf, err_ovr, done_err}, 3'b011);
        pulse(clr_adc);
        step();
        chk("R2 idle after clears", irq, 1'b0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule